// File: doc/BRIEF.md
# Sequential Multiply-Divide Unit with Result Pair

This block is an iterative 32-bit integer multiply and divide engine that owns a dedicated pair of result registers, called HI and LO here. A single-cycle start pulse launches one of four operations: signed multiply, unsigned multiply, signed divide or unsigned divide. It captures two operands and raises busy while it works. A multiply leaves the full 64-bit product split across HI (upper word) and LO (lower word). A divide leaves the quotient in LO and the remainder in HI.

Operands are first turned into magnitudes. An unsigned core then runs one shift-add or restoring-subtract step per cycle for 32 cycles. A final cycle applies the sign correction, writes HI and LO, and pulses done. The unit never signals an arithmetic exception. A zero divisor yields an unspecified result, but the unit still completes on the normal schedule.

A move-from read port returns HI or LO according to a select pin. Both registers are also visible directly. The command side is a plain start pulse gated by busy, not a valid/ready stream. A command offered while busy is dropped rather than held back, so a caller must wait for busy to be low before it issues the next command.

Top module: `muldiv_hilo`

## Requirements
- R1: The operation select op uses bit 1 to choose divide (1) or multiply (0) and bit 0 to choose unsigned (1) or signed (0): 2'b00 signed multiply, 2'b01 unsigned multiply, 2'b10 signed divide, 2'b11 unsigned divide.
- R2: An unsigned multiply leaves the 64-bit product of opa and opb with bits 63:32 in HI and bits 31:0 in LO.
- R3: A signed multiply treats both operands as two's complement and leaves the 64-bit two's complement product in HI (upper) and LO (lower).
- R4: An unsigned divide with a nonzero divisor leaves the quotient opa/opb in LO and the remainder in HI.
- R5: A signed divide with a nonzero divisor truncates the quotient toward zero and gives the remainder the sign of the dividend; 0x80000000 divided by 0xFFFFFFFF gives LO=0x80000000 and HI=0.
- R6: A start seen at a clock edge while idle makes busy high for exactly 33 cycles. In the cycle after the last of them, busy is low, done is high for exactly one cycle, and HI and LO already hold the new result.
- R7: A start pulse that arrives while busy is high is ignored: the running operation, its timing and its result are unchanged.
- R8: HI and LO keep their previous values for the whole time busy is high and change only at completion.
- R9: A zero divisor (signed or unsigned) still completes with the timing of R6, and the unit accepts the next command afterwards.
- R10: rd_data equals HI when rd_sel_hi is 1 and LO when rd_sel_hi is 0.
- R11: After reset, HI and LO are zero and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse, taken only while idle |
| op | input | 2 | Operation select (bit 1 divide, bit 0 unsigned) |
| opa | input | 32 | First operand (multiplicand or dividend) |
| opb | input | 32 | Second operand (multiplier or divisor) |
| rd_sel_hi | input | 1 | Read port select: 1 for HI, 0 for LO |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when HI and LO have been written |
| hi_o | output | 32 | HI register |
| lo_o | output | 32 | LO register |
| rd_data | output | 32 | Move-from read data |

## Verification
The bench aims at the sign corner cases. These are mixed-sign divides, the most negative dividend over minus one, and the most negative value squared. A design that corrects the quotient sign but forgets the remainder sign, or that negates only the low word of a product, shows a wrong HI value there. Busy is compared cycle by cycle, so an off-by-one iteration count changes the busy length and the done cycle. A second start pulse in mid-operation would replace the result or restart the count if the idle gate were missing. Zero divisors check that the unit still finishes on time instead of hanging or cutting the operation short.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  // Bit positions inside the operation select
  localparam int OP_UNS_BIT = 0;
  localparam int OP_DIV_BIT = 1;

  typedef enum logic [1:0] {
    OP_MUL_S = 2'b00,
    OP_MUL_U = 2'b01,
    OP_DIV_S = 2'b10,
    OP_DIV_U = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } md_state_e;

endpackage

// File: rtl/muldiv_prep.sv
// Operand conditioning: signed operands become magnitudes, sign outcomes kept
module muldiv_prep
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         neg_main,
  output logic         neg_aux
);
  logic is_signed;
  logic sgn_a;
  logic sgn_b;

  always_comb begin
    is_signed = ~op[OP_UNS_BIT];
    sgn_a     = is_signed & opa[W-1];
    sgn_b     = is_signed & opb[W-1];
    mag_a     = sgn_a ? (~opa + 1'b1) : opa;
    mag_b     = sgn_b ? (~opb + 1'b1) : opb;
    neg_main  = sgn_a ^ sgn_b;   // product or quotient negative
    neg_aux   = sgn_a;           // remainder follows the dividend
  end
endmodule

// File: rtl/muldiv_mul_step.sv
// One shift-add iteration: partial product upper half plus multiplier shifting out
module muldiv_mul_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] part_hi,
  input  logic [W-1:0] part_lo,
  input  logic [W-1:0] addend,
  output logic [W-1:0] nxt_hi,
  output logic [W-1:0] nxt_lo
);
  logic [W:0] sum;

  always_comb begin
    sum    = {1'b0, part_hi} + (part_lo[0] ? {1'b0, addend} : {(W+1){1'b0}});
    nxt_hi = sum[W:1];
    nxt_lo = {sum[0], part_lo[W-1:1]};
  end
endmodule

// File: rtl/muldiv_div_step.sv
// One restoring-division iteration: remainder in part_hi, dividend/quotient in part_lo
module muldiv_div_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] part_hi,
  input  logic [W-1:0] part_lo,
  input  logic [W-1:0] addend,
  output logic [W-1:0] nxt_hi,
  output logic [W-1:0] nxt_lo
);
  logic [W:0] shifted;
  logic [W:0] trial;
  logic       fits;

  always_comb begin
    shifted = {part_hi, part_lo[W-1]};
    trial   = shifted - {1'b0, addend};
    fits    = ~trial[W];
    nxt_hi  = fits ? trial[W-1:0] : shifted[W-1:0];
    nxt_lo  = {part_lo[W-2:0], fits};
  end
endmodule

// File: rtl/muldiv_fix.sv
// Final sign correction of the unsigned core result
module muldiv_fix #(
  parameter int W = 32
) (
  input  logic         is_div,
  input  logic         neg_main,
  input  logic         neg_aux,
  input  logic [W-1:0] raw_hi,
  input  logic [W-1:0] raw_lo,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  localparam int PW = 2 * W;

  logic [PW-1:0] prod;
  logic [PW-1:0] prod_neg;

  always_comb begin
    prod     = {raw_hi, raw_lo};
    prod_neg = ~prod + {{(PW-1){1'b0}}, 1'b1};
    if (is_div) begin
      res_lo = neg_main ? (~raw_lo + 1'b1) : raw_lo;
      res_hi = neg_aux  ? (~raw_hi + 1'b1) : raw_hi;
    end else begin
      {res_hi, res_lo} = neg_main ? prod_neg : prod;
    end
  end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         rd_sel_hi,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] rd_data
);
  localparam int          CW   = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  md_state_e   state;
  logic [CW-1:0] iter;
  logic        is_div_q;
  logic        neg_main_q;
  logic        neg_aux_q;
  logic [W-1:0] addend_q;
  logic [W-1:0] acc_hi;
  logic [W-1:0] acc_lo;
  logic [W-1:0] hi_q;
  logic [W-1:0] lo_q;
  logic        done_q;

  logic [W-1:0] mag_a, mag_b;
  logic         neg_main, neg_aux;
  logic [W-1:0] mul_hi, mul_lo, div_hi, div_lo;
  logic [W-1:0] step_hi, step_lo;
  logic [W-1:0] res_hi, res_lo;

  muldiv_prep #(.W(W)) u_prep (
    .op       (op),
    .opa      (opa),
    .opb      (opb),
    .mag_a    (mag_a),
    .mag_b    (mag_b),
    .neg_main (neg_main),
    .neg_aux  (neg_aux)
  );

  muldiv_mul_step #(.W(W)) u_mul (
    .part_hi (acc_hi),
    .part_lo (acc_lo),
    .addend  (addend_q),
    .nxt_hi  (mul_hi),
    .nxt_lo  (mul_lo)
  );

  muldiv_div_step #(.W(W)) u_div (
    .part_hi (acc_hi),
    .part_lo (acc_lo),
    .addend  (addend_q),
    .nxt_hi  (div_hi),
    .nxt_lo  (div_lo)
  );

  muldiv_fix #(.W(W)) u_fix (
    .is_div   (is_div_q),
    .neg_main (neg_main_q),
    .neg_aux  (neg_aux_q),
    .raw_hi   (acc_hi),
    .raw_lo   (acc_lo),
    .res_hi   (res_hi),
    .res_lo   (res_lo)
  );

  always_comb begin
    step_hi = is_div_q ? div_hi : mul_hi;
    step_lo = is_div_q ? div_lo : mul_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      iter       <= '0;
      is_div_q   <= 1'b0;
      neg_main_q <= 1'b0;
      neg_aux_q  <= 1'b0;
      addend_q   <= '0;
      acc_hi     <= '0;
      acc_lo     <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state      <= ST_RUN;
            iter       <= '0;
            is_div_q   <= op[OP_DIV_BIT];
            neg_main_q <= neg_main;
            neg_aux_q  <= neg_aux;
            addend_q   <= op[OP_DIV_BIT] ? mag_b : mag_a;
            acc_hi     <= '0;
            acc_lo     <= op[OP_DIV_BIT] ? mag_a : mag_b;
          end
        end
        ST_RUN: begin
          acc_hi <= step_hi;
          acc_lo <= step_lo;
          iter   <= iter + 1'b1;
          if (iter == LAST) state <= ST_FIX;
        end
        ST_FIX: begin
          hi_q   <= res_hi;
          lo_q   <= res_lo;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state != ST_IDLE);
  assign done    = done_q;
  assign hi_o    = hi_q;
  assign lo_o    = lo_q;
  assign rd_data = rd_sel_hi ? hi_q : lo_q;

endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o
);
  localparam int CW = $clog2(W + 2) + 1;

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt <= CW'(W)));  // R6

  AST_BUSY_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == CW'(W + 1)));  // R6

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($fell(busy) && !busy));  // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R6

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(hi_o) && $stable(lo_o)));  // R8

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && (run_cnt < CW'(W))) |=> busy);  // R7

endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .hi_o  (hi_o),
  .lo_o  (lo_o)
);

// File: tb/muldiv_hilo_test.sv
`timescale 1ns/100ps
module muldiv_hilo_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   op = 2'b00;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic         rd_sel_hi = 1'b0;
  logic         busy, done;
  logic [W-1:0] hi_o, lo_o, rd_data;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R11";

  always #2.5 clk = ~clk;

  muldiv_hilo #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .rd_sel_hi(rd_sel_hi), .busy(busy), .done(done), .hi_o(hi_o), .lo_o(lo_o),
    .rd_data(rd_data)
  );

  // ---------------- behavioural reference model ----------------
  int           m_left;
  bit           m_done, m_undef_now, m_idle;
  logic [W-1:0] m_hi, m_lo, p_hi, p_lo;
  bit           p_undef;
  longint       s_a, s_b, s_q, s_r;
  logic [63:0]  u_p;

  task automatic compute(input logic [1:0] c_op, input logic [W-1:0] a, input logic [W-1:0] b);
    p_undef = 0;
    s_a = longint'($signed(a));
    s_b = longint'($signed(b));
    case (c_op)
      2'b00: begin u_p = 64'(s_a * s_b); p_hi = u_p[63:32]; p_lo = u_p[31:0]; end
      2'b01: begin u_p = {32'b0, a} * {32'b0, b}; p_hi = u_p[63:32]; p_lo = u_p[31:0]; end
      2'b10: begin
        if (b == 0) p_undef = 1;
        else begin s_q = s_a / s_b; s_r = s_a % s_b; p_lo = s_q[31:0]; p_hi = s_r[31:0]; end
      end
      default: begin
        if (b == 0) p_undef = 1;
        else begin p_lo = a / b; p_hi = a % b; end
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_hi = '0; m_lo = '0; m_done = 0; m_undef_now = 0;
    end else begin
      if (m_undef_now) begin m_hi = hi_o; m_lo = lo_o; end
      m_idle = (m_left == 0);
      m_done = 0;
      m_undef_now = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin
          m_done = 1;
          if (p_undef) m_undef_now = 1;
          else begin m_hi = p_hi; m_lo = p_lo; end
        end
      end
      if (m_idle && start) begin
        compute(op, opa, opb);
        m_left = W + 1;
      end
    end
  end

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, "busy", 64'(busy), 64'(m_left > 0));
      check(cur_req, "done", 64'(done), 64'(m_done));
      if (!m_undef_now) begin
        check(cur_req, "hi", 64'(hi_o), 64'(m_hi));                  // R8 hold
        check(cur_req, "lo", 64'(lo_o), 64'(m_lo));
        check("R10", "rd_data", 64'(rd_data), 64'(rd_sel_hi ? m_hi : m_lo));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic issue(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk); #1;
    start = 1'b1; op = o; opa = a; opb = b;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      rd_sel_hi = ~rd_sel_hi;
    end
  endtask

  task automatic run_op(input string req, input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] exp_hi, input logic [W-1:0] exp_lo);
    cur_req = req;
    issue(o, a, b);
    wait_cycles(34);
    check(req, "final hi", 64'(hi_o), 64'(exp_hi));
    check(req, "final lo", 64'(lo_o), 64'(exp_lo));
  endtask

  task automatic measure_busy(input string req, input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
    int n;
    cur_req = req;
    issue(o, a, b);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); #1; end
    check(req, "busy length", 64'(n), 64'(33));
    check(req, "done at end", 64'(done), 64'd1);
    @(negedge clk); #1;
    check(req, "done one cycle", 64'(done), 64'd0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "busy", 64'(busy), 64'd0);
    check("R11", "done", 64'(done), 64'd0);
    check("R11", "hi", 64'(hi_o), 64'd0);
    check("R11", "lo", 64'(lo_o), 64'd0);
    #1 rst_n = 1'b1;
    wait_cycles(2);

    // R2 unsigned multiply
    run_op("R2", 2'b01, 32'd7, 32'd9, 32'h0, 32'd63);
    run_op("R2", 2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h00000001);
    run_op("R2", 2'b01, 32'h80000000, 32'h00000002, 32'h00000001, 32'h0);
    // R3 signed multiply
    run_op("R3", 2'b00, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h1);
    run_op("R3", 2'b00, 32'hFFFFFFFD, 32'd5, 32'hFFFFFFFF, 32'hFFFFFFF1);
    run_op("R3", 2'b00, 32'h80000000, 32'h80000000, 32'h40000000, 32'h0);
    // R4 unsigned divide
    run_op("R4", 2'b11, 32'd2037, 32'd10, 32'd7, 32'd203);
    run_op("R4", 2'b11, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF, 32'h1);
    run_op("R4", 2'b11, 32'd5, 32'd9, 32'd5, 32'd0);
    // R5 signed divide
    run_op("R5", 2'b10, -32'sd7, 32'sd2, -32'sd1, -32'sd3);
    run_op("R5", 2'b10, 32'sd7, -32'sd2, 32'sd1, -32'sd3);
    run_op("R5", 2'b10, -32'sd7, -32'sd2, -32'sd1, 32'sd3);
    run_op("R5", 2'b10, 32'h80000000, 32'hFFFFFFFF, 32'h0, 32'h80000000);

    // R6 timing
    measure_busy("R6", 2'b00, 32'd12345, 32'd678);
    measure_busy("R6", 2'b11, 32'd1000, 32'd3);

    // R7 start while busy is dropped
    cur_req = "R7";
    issue(2'b01, 32'd11, 32'd13);
    wait_cycles(5);
    issue(2'b11, 32'd100, 32'd7);
    wait_cycles(10);
    issue(2'b00, 32'hFFFFFFFF, 32'd2);
    wait_cycles(20);
    check("R7", "hi after ignored start", 64'(hi_o), 64'd0);
    check("R7", "lo after ignored start", 64'(lo_o), 64'd143);
    check("R7", "idle after first op", 64'(busy), 64'd0);

    // R9 zero divisor completes
    measure_busy("R9", 2'b11, 32'd1234, 32'd0);
    measure_busy("R9", 2'b10, -32'sd55, 32'd0);
    run_op("R9", 2'b01, 32'd3, 32'd4, 32'd0, 32'd12);

    // R1 mixed operation codes, random operands
    cur_req = "R1";
    for (int k = 0; k < 40; k++) begin
      logic [1:0]   ro;
      logic [W-1:0] ra, rb;
      ro = 2'($urandom_range(0, 3));
      ra = $urandom;
      rb = (k % 5 == 0) ? W'($urandom_range(1, 20)) : $urandom;
      if (k % 7 == 3) ra = 32'h80000000;
      issue(ro, ra, rb);
      wait_cycles(34 + (k % 3));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule